// File: doc/BRIEF.md
# Data-Polling Completion Checker

This block sits on the host side of a flash memory and decides when a program or erase operation that was started earlier has finished, and whether it finished cleanly. A single start pulse hands it the operation kind, the byte that was written (for a program) and the address to poll. It then reads that address over a simple synchronous request/acknowledge bus and judges each returned status byte by the data-polling method. Bit 7 of the status byte is the completion bit. Bit 5 is the exceeded-limit bit.

If the completion bit matches the expected value, the operation is reported as good. While the completion bit differs and the limit bit is clear, the block reads again. When the limit bit is seen set, the completion bit may have flipped at the same moment, so the block makes one more read and tests the completion bit again before it declares a failure. A failure, either a device timeout or the block's own poll-count watchdog expiring, is followed by a single bus write of a reset byte to the polling address, which returns the device to read mode. The block stays busy until that write has been acknowledged.

The results stay on the outputs until the next start is accepted.

Top module: `dpoll_checker`

## Requirements
- R1: A start pulse while idle captures the operation kind, the expected byte and the polling address. It clears all result flags, makes `busy` high on the following cycle, and issues reads only to the captured address.
- R2: For a program (`op_erase`=0), a read whose bit 7 equals bit 7 of the expected byte ends the operation with `done`=1 and `ok`=1. No bus write is issued, and the other bits of the read byte are ignored.
- R3: For an erase (`op_erase`=1), a read whose bit 7 is 1 ends the operation with `done`=1 and `ok`=1. No bus write is issued.
- R4: A read whose bit 7 does not match and whose bit 5 is 0 is followed by another read of the same address.
- R5: A read whose bit 7 does not match and whose bit 5 is 1 is followed by exactly one more read. If that read's bit 7 matches, the result is `ok` with no error and no write.
- R6: If that second read also does not match, `timeout_err` is set. Then exactly one bus write of `RESET_BYTE` (default 0xF0) to the polling address is issued, and `busy` stays high until it is acknowledged.
- R7: After `MAX_POLLS` consecutive non-matching reads that all have bit 5 equal to 0, `hang_err` is set and the same reset write is issued. A match on the `MAX_POLLS`-th read still gives `ok`.
- R8: `done` and exactly one of `ok`, `timeout_err` and `hang_err` hold their values until the next accepted start. A start that arrives while `busy` is high is ignored.
- R9: After reset the block is idle, with `busy`, `bus_req`, `done` and every result flag at 0.
- R10: A bus request holds its address and direction unchanged until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins polling |
| op_erase | input | 1 | 1 = erase operation, 0 = program operation |
| exp_data | input | DW | Byte that was programmed; bit 7 is the one compared |
| poll_addr | input | AW | Address to poll |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write (reset command), 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data (reset byte) |
| bus_ack | input | 1 | Bus acknowledge; read data valid with it |
| bus_rdata | input | DW | Status byte returned by a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result available |
| ok | output | 1 | Operation completed successfully |
| timeout_err | output | 1 | Device reported exceeded time limit |
| hang_err | output | 1 | Poll-count watchdog expired |

## Verification
The assertions check, on every cycle, that a pending request keeps its address and direction, that `done` and `busy` are never high together, and that at most one result flag is set. They also check that results stay frozen while idle, that a timeout flag only appears after a failed second read, and that the poll counter stays within its limit. Only the bench scenarios show that the right outcome follows from a given sequence of status bytes: the number of reads made, the presence and content of the reset write, the mandatory second read, the exact watchdog boundary, and that a start during a busy period has no effect.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_RESET = 2'd3
  } dpoll_state_e;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } dpoll_op_e;

endpackage

// File: rtl/dpoll_judge.sv
module dpoll_judge
  import dpoll_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DONE_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  dpoll_op_e         op,
  input  logic              exp_bit,
  input  logic [DW-1:0]     rdata,
  output logic              pass,
  output logic              limit
);

  logic target;
  logic unused_rbits;

  // erase drives the completion bit to 1; a program drives it to the data bit
  assign target       = (op == OP_ERASE) ? 1'b1 : exp_bit;
  assign pass         = (rdata[DONE_BIT] == target);
  assign limit        = rdata[LIMIT_BIT];
  assign unused_rbits = ^rdata;

endmodule

// File: rtl/dpoll_watchdog.sv
module dpoll_watchdog #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expired
);

  localparam int CW = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = step && (cnt_q == LAST);
  assign cnt_en  = clr || step;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/dpoll_seq.sv
module dpoll_seq
  import dpoll_pkg::*;
#(
  parameter int              DW         = 8,
  parameter int              AW         = 18,
  parameter int              DONE_BIT   = 7,
  parameter logic [DW-1:0]   RESET_BYTE = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_erase,
  input  logic [DW-1:0]   exp_data,
  input  logic [AW-1:0]   poll_addr,
  input  logic            bus_ack,
  input  logic            pass,
  input  logic            limit,
  input  logic            expired,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            busy,
  output logic            done,
  output logic            ok,
  output logic            timeout_err,
  output logic            hang_err,
  output dpoll_op_e       ctx_op,
  output logic            ctx_bit,
  output logic            step,
  output logic            clr
);

  dpoll_state_e    state_q, state_d;
  dpoll_op_e       op_q;
  logic            bit_q;
  logic [AW-1:0]   addr_q;
  logic            done_q, done_d;
  logic            ok_q, ok_d;
  logic            to_q, to_d;
  logic            hang_q, hang_d;
  logic            accept;
  logic            unused_exp;

  assign accept     = (state_q == ST_IDLE) && start;
  assign unused_exp = ^exp_data;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    ok_d    = ok_q;
    to_d    = to_q;
    hang_d  = hang_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_POLL;
          done_d  = 1'b0;
          ok_d    = 1'b0;
          to_d    = 1'b0;
          hang_d  = 1'b0;
        end
      end
      ST_POLL: begin
        if (bus_ack) begin
          if (pass) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            ok_d    = 1'b1;
          end else if (limit) begin
            state_d = ST_RECHK;
          end else if (expired) begin
            state_d = ST_RESET;
            hang_d  = 1'b1;
          end
        end
      end
      ST_RECHK: begin
        if (bus_ack) begin
          if (pass) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            ok_d    = 1'b1;
          end else begin
            state_d = ST_RESET;
            to_d    = 1'b1;
          end
        end
      end
      ST_RESET: begin
        if (bus_ack) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      bit_q   <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      to_q    <= 1'b0;
      hang_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= dpoll_op_e'(op_erase);
        bit_q  <= exp_data[DONE_BIT];
        addr_q <= poll_addr;
      end
      done_q <= done_d;
      ok_q   <= ok_d;
      to_q   <= to_d;
      hang_q <= hang_d;
    end
  end

  assign step        = (state_q == ST_POLL) && bus_ack && !pass && !limit;
  assign clr         = accept;
  assign bus_req     = (state_q != ST_IDLE);
  assign bus_we      = (state_q == ST_RESET);
  assign bus_addr    = addr_q;
  assign bus_wdata   = RESET_BYTE;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign ok          = ok_q;
  assign timeout_err = to_q;
  assign hang_err    = hang_q;
  assign ctx_op      = op_q;
  assign ctx_bit     = bit_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, timeout_err, hang_err}));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable({ok, timeout_err, hang_err})));

  // R6
  to_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(state_q == ST_RECHK && bus_ack && !pass));

  // R6
  busy_until_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_ack) |=> busy);

  // R7
  hang_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hang_err) |-> $past(state_q == ST_POLL && bus_ack && !pass && !limit));

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker
  import dpoll_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            AW         = 18,
  parameter int            DONE_BIT   = 7,
  parameter int            LIMIT_BIT  = 5,
  parameter int            MAX_POLLS  = 4096,
  parameter logic [DW-1:0] RESET_BYTE = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_erase,
  input  logic [DW-1:0]   exp_data,
  input  logic [AW-1:0]   poll_addr,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata,
  output logic            busy,
  output logic            done,
  output logic            ok,
  output logic            timeout_err,
  output logic            hang_err
);

  logic [1:0]  rst_pipe_q;
  logic        rst_sync_n;
  dpoll_op_e   ctx_op;
  logic        ctx_bit;
  logic        pass, limit, expired, step, clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  dpoll_judge #(
    .DW        (DW),
    .DONE_BIT  (DONE_BIT),
    .LIMIT_BIT (LIMIT_BIT)
  ) u_judge (
    .op      (ctx_op),
    .exp_bit (ctx_bit),
    .rdata   (bus_rdata),
    .pass    (pass),
    .limit   (limit)
  );

  dpoll_watchdog #(
    .MAX_POLLS (MAX_POLLS)
  ) u_wdog (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr),
    .step    (step),
    .expired (expired)
  );

  dpoll_seq #(
    .DW         (DW),
    .AW         (AW),
    .DONE_BIT   (DONE_BIT),
    .RESET_BYTE (RESET_BYTE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .op_erase    (op_erase),
    .exp_data    (exp_data),
    .poll_addr   (poll_addr),
    .bus_ack     (bus_ack),
    .pass        (pass),
    .limit       (limit),
    .expired     (expired),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .done        (done),
    .ok          (ok),
    .timeout_err (timeout_err),
    .hang_err    (hang_err),
    .ctx_op      (ctx_op),
    .ctx_bit     (ctx_bit),
    .step        (step),
    .clr         (clr)
  );

endmodule

// File: tb/dpoll_checker_test.sv
module dpoll_checker_test;

  localparam int         MAXP = 6;
  localparam logic [7:0] RB   = 8'hF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_erase = 1'b0;
  logic [7:0]  exp_data = '0;
  logic [17:0] poll_addr = '0;
  logic        bus_req, bus_we;
  logic [17:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ack = 1'b0;
  logic [7:0]  bus_rdata = '0;
  logic        busy, done, ok, timeout_err, hang_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  resp [32];
  int          rd_idx, n_rd, n_wr, wait_n;
  logic        addr_bad, slow;
  logic [7:0]  last_wd;
  logic [17:0] last_wa, cur_addr;

  dpoll_checker #(
    .DW (8), .AW (18), .DONE_BIT (7), .LIMIT_BIT (5),
    .MAX_POLLS (MAXP), .RESET_BYTE (RB)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start (start), .op_erase (op_erase),
    .exp_data (exp_data), .poll_addr (poll_addr),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_ack (bus_ack), .bus_rdata (bus_rdata),
    .busy (busy), .done (done), .ok (ok),
    .timeout_err (timeout_err), .hang_err (hang_err)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // bus responder
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wait_n != 0) begin
        wait_n--;
      end else begin
        bus_ack = 1'b1;
        if (bus_addr != cur_addr) addr_bad = 1'b1;
        if (bus_we) begin
          n_wr++;
          last_wd = bus_wdata;
          last_wa = bus_addr;
        end else begin
          n_rd++;
          bus_rdata = resp[rd_idx % 32];
          rd_idx++;
        end
        wait_n = slow ? 3 : $urandom_range(0, 2);
      end
    end
  end

  task automatic chk(input bit good, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic void fill(input logic [7:0] v);
    for (int i = 0; i < 32; i++) resp[i] = v;
  endfunction

  // outcome model: 0 ok, 1 device timeout, 2 watchdog hang
  function automatic void model(input bit erase, input logic [7:0] expv,
                                output int res, output int reads, output int writes);
    int polls = 0;
    int i = 0;
    logic tgt;
    logic [7:0] b;
    tgt = erase ? 1'b1 : expv[7];
    res = -1;
    reads = 0;
    while (res < 0) begin
      b = resp[i]; i++; reads++;
      if (b[7] == tgt) res = 0;
      else if (b[5]) begin
        b = resp[i]; i++; reads++;
        res = (b[7] == tgt) ? 0 : 1;
      end else begin
        polls++;
        if (polls == MAXP) res = 2;
      end
    end
    writes = (res == 0) ? 0 : 1;
  endfunction

  task automatic run_op(input bit erase, input logic [7:0] expv,
                        input logic [17:0] addr, input string tag, input bit inject);
    int res, reads, writes;
    logic [3:0] flags;
    @(negedge clk);
    n_rd = 0; n_wr = 0; rd_idx = 0; addr_bad = 1'b0; cur_addr = addr;
    op_erase = erase; exp_data = expv; poll_addr = addr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    chk(done == 1'b0, "R1", "done cleared by start", int'(done), 0);
    if (inject) begin
      @(negedge clk);
      op_erase = ~erase; exp_data = ~expv; poll_addr = addr ^ 18'h1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    model(erase, expv, res, reads, writes);
    chk(done == 1'b1, tag, "done", int'(done), 1);
    chk(ok == (res == 0), tag, "ok", int'(ok), int'(res == 0));
    chk(timeout_err == (res == 1), tag, "timeout_err", int'(timeout_err), int'(res == 1));
    chk(hang_err == (res == 2), tag, "hang_err", int'(hang_err), int'(res == 2));
    chk(n_rd == reads, tag, "read count", n_rd, reads);
    chk(n_wr == writes, tag, "write count", n_wr, writes);
    if (writes != 0) begin
      chk(last_wd == RB, "R6", "reset byte", int'(last_wd), int'(RB));
      chk(last_wa == addr, "R6", "reset address", int'(last_wa), int'(addr));
    end
    chk(addr_bad == 1'b0, "R10", "bus address", int'(addr_bad), 0);
    flags = {done, ok, timeout_err, hang_err};
    repeat (4) @(negedge clk);
    chk({done, ok, timeout_err, hang_err} == flags, "R8", "results held",
        int'({done, ok, timeout_err, hang_err}), int'(flags));
  endtask

  initial begin
    void'($urandom(32'd7321));
    fill(8'h00);
    rd_idx = 0; n_rd = 0; n_wr = 0; wait_n = 0;
    addr_bad = 1'b0; slow = 1'b0; cur_addr = '0;
    last_wd = '0; last_wa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && bus_req == 1'b0, "R9", "idle after reset", int'({busy, bus_req}), 0);
    chk({done, ok, timeout_err, hang_err} == 4'b0, "R9", "flags after reset",
        int'({done, ok, timeout_err, hang_err}), 0);

    // R2 program, bit 7 of expected is 0, other bits differ
    fill(8'h00); resp[0] = 8'h7F;
    run_op(1'b0, 8'h5A, 18'h01234, "R2", 1'b0);
    // R2 program, bit 7 expected 1
    fill(8'h80); resp[0] = 8'h00;
    run_op(1'b0, 8'hC3, 18'h3FFFF, "R2", 1'b0);
    // R3 erase completes after two plain mismatches (R4)
    fill(8'h80); resp[0] = 8'h00; resp[1] = 8'h44;
    run_op(1'b1, 8'h00, 18'h20000, "R3", 1'b0);
    // R4 program keeps reading
    fill(8'h00); resp[0] = 8'h80; resp[1] = 8'h80; resp[2] = 8'h80;
    run_op(1'b0, 8'h12, 18'h00010, "R4", 1'b0);
    // R5 limit bit then match on second read
    fill(8'h00); resp[0] = 8'h20; resp[1] = 8'hA0;
    run_op(1'b0, 8'hFF, 18'h00555, "R5", 1'b0);
    // R6 limit bit then mismatch again
    fill(8'h00); resp[0] = 8'h20; resp[1] = 8'h20;
    run_op(1'b1, 8'h00, 18'h0AAAA, "R6", 1'b0);
    // R7 watchdog expiry exactly at MAXP polls
    fill(8'h80);
    run_op(1'b0, 8'h00, 18'h00777, "R7", 1'b0);
    // R7 boundary: match on the last allowed poll
    fill(8'h80); resp[MAXP-1] = 8'h00;
    run_op(1'b0, 8'h00, 18'h00778, "R7", 1'b0);
    // R8 start during busy ignored
    slow = 1'b1;
    fill(8'h00); resp[0] = 8'h80;
    run_op(1'b0, 8'h00, 18'h01000, "R8", 1'b1);
    slow = 1'b0;

    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 32; i++) begin
        resp[i] = 8'($urandom) & 8'hDF;
        if ($urandom_range(0, 5) == 0) resp[i][5] = 1'b1;
        if ($urandom_range(0, 2) != 0) resp[i][7] = ~resp[i][7];
      end
      run_op(1'($urandom), 8'($urandom), 18'($urandom), "R4", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule